// File: doc/BRIEF.md
# Static Branch Predictor with Squash

This block makes a fixed, history-free guess for a conditional branch while the branch is in the decode stage. It then tracks the instructions fetched on the guessed path until the branch resolves in execute. If the hint input is enabled, a compiler-supplied hint bit decides the direction. Otherwise the direction comes from comparing addresses: a branch that jumps backward is guessed taken, and any other branch is guessed not taken. A taken guess sends a fetch redirect to the target. A not-taken guess lets fetch continue sequentially.

The block remembers one unresolved branch. While that branch is outstanding, a hold output tells the pipeline that the younger instructions are speculative and must not write registers or memory. The execute stage reports the real outcome. If the guess was right, the hold drops on the next cycle. If it was wrong, the block does three things in the same cycle: it asserts squash for the fetch and decode stages, it redirects fetch to the correct path, and it bumps a saturating misprediction counter.

Top module: `brpred_squash`

## Requirements
- R1: After reset, pred_taken, redirect_valid, squash_dec, squash_fet and spec_hold are 0 and miss_count is 0.
- R2: With dec_hint_en low, a decoding branch is predicted taken exactly when dec_target is numerically lower than dec_pc. An equal or higher target is predicted not taken, and dec_hint is ignored.
- R3: With dec_hint_en high, pred_taken equals dec_hint regardless of the address comparison.
- R4: A taken prediction raises redirect_valid in the same cycle with redirect_pc equal to dec_target. A not-taken prediction leaves redirect_valid low.
- R5: A resolution whose ex_taken differs from the stored prediction raises squash_dec and squash_fet in that cycle, together with redirect_valid. redirect_pc is the stored target if ex_taken is 1, else the stored branch address plus INSTR_BYTES (4 by default).
- R6: spec_hold is 1 from the cycle after a branch is accepted at decode until its resolution cycle inclusive. A correct resolution clears it on the next cycle with no squash and no redirect.
- R7: ex_valid while no branch is outstanding has no effect: no squash, no redirect, and miss_count unchanged.
- R8: miss_count increases by one in the cycle after each misprediction, and it holds at its all-ones maximum (CNT_W bits, 16 by default).
- R9: A branch in decode during a squash cycle is discarded: pred_taken stays 0 and spec_hold is 0 on the next cycle.
- R10: The prediction keeps no history: the same branch receives the same prediction after any number of mispredictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Conditional branch present in decode |
| dec_pc | input | AW | Address of the decoding branch |
| dec_target | input | AW | Target address of the decoding branch |
| dec_hint | input | 1 | Compiler direction hint (1 = taken) |
| dec_hint_en | input | 1 | Use dec_hint instead of the address comparison |
| ex_valid | input | 1 | Branch resolving in execute |
| ex_taken | input | 1 | Actual branch outcome |
| pred_taken | output | 1 | Predicted direction for the decoding branch |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | AW | Fetch restart address |
| squash_dec | output | 1 | Invalidate the decode-stage instruction |
| squash_fet | output | 1 | Invalidate the fetch-stage instruction |
| spec_hold | output | 1 | Younger instructions are speculative; block architectural writes |
| miss_count | output | CNT_W | Saturating misprediction count |

## Verification
The bench checks the comparison at equal addresses and at the address-space edges. A design that uses a less-or-equal test would wrongly predict a self-loop as taken. It also checks that the hint wins when enabled and is ignored when disabled. A mix-up there would flip the predictions of forward-hinted branches. On a misprediction, the bench checks both recovery addresses. A design that picks the wrong one restarts fetch on the guessed path again. Three further cases cover a branch arriving in decode during a squash, a resolve with nothing outstanding, and a counter driven past all-ones. A wrong design there would leave a stale hold, squash good instructions, or wrap the count to zero.

// File: rtl/brpred_squash.sv
module brpred_squash #(
  parameter int AW          = 32,
  parameter int CNT_W       = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [AW-1:0]    dec_pc,
  input  logic [AW-1:0]    dec_target,
  input  logic             dec_hint,
  input  logic             dec_hint_en,
  input  logic             ex_valid,
  input  logic             ex_taken,
  output logic             pred_taken,
  output logic             redirect_valid,
  output logic [AW-1:0]    redirect_pc,
  output logic             squash_dec,
  output logic             squash_fet,
  output logic             spec_hold,
  output logic [CNT_W-1:0] miss_count
);

  logic             pend_q, pend_pred_q;
  logic [AW-1:0]    pend_pc_q, pend_tgt_q;
  logic [CNT_W-1:0] cnt_q;

  wire miss     = ex_valid && pend_q && (ex_taken != pend_pred_q);
  wire guess    = dec_hint_en ? dec_hint : (dec_target < dec_pc);
  wire dec_live = dec_valid && !miss;

  assign pred_taken     = dec_live && guess;
  assign squash_dec     = miss;
  assign squash_fet     = miss;
  assign redirect_valid = miss || pred_taken;
  assign redirect_pc    = miss ? (ex_taken ? pend_tgt_q : pend_pc_q + AW'(INSTR_BYTES))
                               : dec_target;
  assign spec_hold      = pend_q;
  assign miss_count     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_pred_q <= 1'b0;
      pend_pc_q   <= '0;
      pend_tgt_q  <= '0;
    end else if (dec_live) begin
      pend_q      <= 1'b1;
      pend_pred_q <= guess;
      pend_pc_q   <= dec_pc;
      pend_tgt_q  <= dec_target;
    end else if (ex_valid && pend_q) begin
      pend_q      <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (miss && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '1) |-> (cnt_q == '1)); // R8
  AST_SQUASH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    squash_dec |-> (redirect_valid && squash_fet && !pred_taken)); // R5
  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && spec_hold && !dec_valid) |=> !spec_hold); // R6
  AST_NO_SQUASH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !spec_hold |-> !squash_dec); // R7

endmodule

// File: tb/brpred_squash_bench.sv
module brpred_squash_bench;
  localparam int AW = 16;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, dec_hint = 0, dec_hint_en = 0, ex_valid = 0, ex_taken = 0;
  logic [AW-1:0] dec_pc = '0, dec_target = '0;
  logic pred_taken, redirect_valid, squash_dec, squash_fet, spec_hold;
  logic [AW-1:0] redirect_pc;
  logic [CW-1:0] miss_count;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  brpred_squash #(.AW(AW), .CNT_W(CW), .INSTR_BYTES(4)) u_brpred_squash (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_target(dec_target), .dec_hint(dec_hint), .dec_hint_en(dec_hint_en),
    .ex_valid(ex_valid), .ex_taken(ex_taken), .pred_taken(pred_taken),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .squash_dec(squash_dec), .squash_fet(squash_fet), .spec_hold(spec_hold),
    .miss_count(miss_count));

  // {hint_en, hint, pc, target, expected prediction}
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 1'b0, 16'h0100, 16'h0080, 1'b1},
    {1'b0, 1'b0, 16'h0100, 16'h0200, 1'b0},
    {1'b0, 1'b0, 16'h0100, 16'h0100, 1'b0},
    {1'b1, 1'b1, 16'h0100, 16'h0200, 1'b1},
    {1'b1, 1'b0, 16'h0100, 16'h0080, 1'b0},
    {1'b0, 1'b1, 16'h0300, 16'h0100, 1'b1},
    {1'b0, 1'b0, 16'hFFF0, 16'h0000, 1'b1},
    {1'b1, 1'b1, 16'h0010, 16'h0010, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic decode(input logic en, input logic h, input logic [AW-1:0] pc,
                        input logic [AW-1:0] tg);
    @(negedge clk);
    ex_valid = 0; dec_valid = 1; dec_hint_en = en; dec_hint = h; dec_pc = pc; dec_target = tg;
    #1;
  endtask

  task automatic resolve(input logic tk);
    @(negedge clk);
    dec_valid = 0; ex_valid = 1; ex_taken = tk;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    dec_valid = 0; ex_valid = 0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pred", pred_taken, 0);
    chk("R1 redirect", redirect_valid, 0);
    chk("R1 squash", {squash_dec, squash_fet}, 0);
    chk("R1 hold", spec_hold, 0);
    chk("R1 count", miss_count, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      decode(VEC[i][34], VEC[i][33], VEC[i][32:17], VEC[i][16:1]);
      chk(VEC[i][34] ? "R3 pred" : "R2 pred", pred_taken, VEC[i][0]);
      chk("R4 redirect", redirect_valid, VEC[i][0]);
      if (VEC[i][0]) chk("R4 redirect_pc", redirect_pc, VEC[i][16:1]);
      resolve(VEC[i][0]);
      chk("R6 hold during resolve", spec_hold, 1);
      chk("R6 no squash on correct", squash_dec, 0);
      chk("R6 no redirect on correct", redirect_valid, 0);
      idle();
      chk("R6 hold cleared", spec_hold, 0);
    end
    chk("R8 no misses yet", miss_count, 0);

    // R5 predicted taken, actually not taken; R9 branch in decode during squash
    decode(0, 0, 16'h0100, 16'h0080);
    @(negedge clk);
    ex_valid = 1; ex_taken = 0; dec_valid = 1; dec_hint_en = 0; dec_pc = 16'h0400; dec_target = 16'h0200;
    #1;
    chk("R5 squash_dec", squash_dec, 1);
    chk("R5 squash_fet", squash_fet, 1);
    chk("R5 redirect", redirect_valid, 1);
    chk("R5 fallthrough pc", redirect_pc, 16'h0104);
    chk("R9 pred gated", pred_taken, 0);
    idle();
    chk("R9 hold dropped", spec_hold, 0);
    chk("R8 count 1", miss_count, 1);

    // R5 predicted not taken, actually taken
    decode(0, 0, 16'h0100, 16'h0300);
    resolve(1);
    chk("R5 squash", squash_dec, 1);
    chk("R5 target pc", redirect_pc, 16'h0300);
    idle();
    chk("R8 count 2", miss_count, 2);

    // R7 resolve with nothing outstanding
    resolve(0);
    chk("R7 no squash", squash_dec, 0);
    chk("R7 no redirect", redirect_valid, 0);
    idle();
    chk("R7 count held", miss_count, 2);

    // R10 same branch, same prediction after repeated misses; R8 saturation
    for (int k = 0; k < 18; k++) begin
      decode(0, 0, 16'h0800, 16'h0700);
      chk("R10 stable prediction", pred_taken, 1);
      resolve(0);
    end
    idle();
    chk("R8 saturated", miss_count, 4'hF);
    chk("R6 hold after last", spec_hold, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule